// File: doc/BRIEF.md
# Machine/Supervisor Control Register File with Write Masks

This block holds the privileged control registers of a small processor core: the status word, the pending, enable and delegation words for interrupts, two trap-vector bases and two counter-enable words. Software reaches them through a 12-bit register address with a write strobe and write data. A read returns the value of the addressed register on the same cycle. Every write passes through a per-register filter, so bits that must not change keep their value and illegal field values are dropped.

The supervisor views of status, pending and enable are not separate storage. They are windows onto the machine registers. For pending and enable, the delegation word acts as a live mask on both reads and writes. For status, a fixed set of supervisor-visible fields forms the window. The summary dirty flag in the top bit of the status word is held consistent with the floating-point and extension state fields. A read of an address that maps to no register returns zero and raises a flag for that cycle.

Top module: `mcsr_filter`

## Requirements
- R1: In the machine pending register (address 0x344), a write changes only bit 1 (supervisor software) and bit 5 (supervisor timer). Every other bit keeps its value.
- R2: In the delegation register (0x303), only bits 1, 5, 9 and 12 are writable. The machine enable register (0x304) accepts those same bits plus bits 3 and 7. All other bits stay zero.
- R3: A write to the machine status register (0x300) changes only these fields: bit 1, bit 3, bit 5, bit 7, bit 8, FS [14:13], bit 17 and bit 18. XS [16:15] is writable only when the EXT_PRESENT parameter is 1 (default 0). MPP [12:11] is written only if the new value is not 2'b10. VM [28:24] is written only if the new value is legal for XLEN: 0 or 8 when XLEN is 32; 0, 9 or 10 when XLEN is 64.
- R4: After each status write, bit XLEN-1 of the status register is 1 exactly when FS is 2'b11 or XS is 2'b11.
- R5: The machine trap vector (0x305) and the supervisor trap vector (0x105) store the write data with bits [1:0] forced to zero.
- R6: The two counter-enable registers (0x320 and 0x321) store only bits [2:0] of the write data. Higher bits read as zero.
- R7: A write to the supervisor pending view (0x144) or the supervisor enable view (0x104) changes only the bits whose delegation bit is 1, and the machine-register filters still apply. A read of either view returns the machine register ANDed with the delegation register.
- R8: The supervisor status view (0x100) shows only bits 1, 5, 8, 13 to 16 and 18, plus bit XLEN-1, which is recomputed from FS and XS. A write through this view changes only those fields.
- R9: While rd_en is high with an address that maps to no register, illegal_access is 1 and rd_data is 0. A write to such an address changes nothing.
- R10: A write takes effect at the rising clock edge at which wr_en is sampled high. A read of the same register in that cycle returns the old value.
- R11: Synchronous reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register address for both the read and the write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | XLEN | Write data |
| rd_en | input | 1 | Read strobe; qualifies the illegal-access flag |
| rd_data | output | XLEN | Value of the addressed register (combinational) |
| illegal_access | output | 1 | Read of an address that maps to no register |

## Verification
The write filters are driven with all-ones data, which shows that each mask lets exactly its own bits through. Sparse patterns are also used. One carries an illegal privilege code together with a legal translation mode, which shows that the two conditional fields are accepted or refused independently. Another sets only the FS bits, which shows that the dirty flag follows FS alone. The supervisor views are tested after the delegation word has been narrowed to one bit. Clearing a view must then disturb only that bit of the machine register, which separates a correct dynamic mask from a fixed one. A write to an unmapped address is followed by a read of a live register to confirm that nothing changed, and a read during a write confirms the old value is returned.

// File: rtl/csr_pkg.sv
package csr_pkg;

    // register addresses decoded by the core
    localparam logic [11:0] A_SSTATUS = 12'h100;
    localparam logic [11:0] A_SIE     = 12'h104;
    localparam logic [11:0] A_STVEC   = 12'h105;
    localparam logic [11:0] A_SIP     = 12'h144;
    localparam logic [11:0] A_MSTATUS = 12'h300;
    localparam logic [11:0] A_MDELEG  = 12'h303;
    localparam logic [11:0] A_MIE     = 12'h304;
    localparam logic [11:0] A_MTVEC   = 12'h305;
    localparam logic [11:0] A_UCNTEN  = 12'h320;
    localparam logic [11:0] A_SCNTEN  = 12'h321;
    localparam logic [11:0] A_MIP     = 12'h344;

    // interrupt bit positions
    localparam int IB_SSW  = 1;
    localparam int IB_MSW  = 3;
    localparam int IB_STMR = 5;
    localparam int IB_MTMR = 7;
    localparam int IB_SEXT = 9;
    localparam int IB_COP  = 12;

    // status field positions
    localparam int SB_SIE  = 1;
    localparam int SB_MIE  = 3;
    localparam int SB_SPIE = 5;
    localparam int SB_MPIE = 7;
    localparam int SB_SPP  = 8;
    localparam int SB_MPP  = 11;
    localparam int SB_FS   = 13;
    localparam int SB_XS   = 15;
    localparam int SB_MPRV = 17;
    localparam int SB_PUM  = 18;
    localparam int SB_VM   = 24;

    localparam int CNTEN_W = 3;

    typedef struct packed {
        logic       sie;
        logic       mie;
        logic       spie;
        logic       mpie;
        logic       spp;
        logic [1:0] mpp;
        logic [1:0] fs;
        logic [1:0] xs;
        logic       mprv;
        logic       pum;
        logic [4:0] vm;
    } status_t;

    // one-hot decode of the address map
    typedef struct packed {
        logic sstatus, sie, stvec, sip;
        logic mstatus, mdeleg, mie, mtvec;
        logic ucnten, scnten, mip;
    } csr_sel_t;

    function automatic logic vm_legal(input int xlen, input logic [4:0] vm);
        if (xlen == 32) return (vm == 5'd0) || (vm == 5'd8);
        if (xlen == 64) return (vm == 5'd0) || (vm == 5'd9) || (vm == 5'd10);
        return vm == 5'd0;
    endfunction

    function automatic logic priv_legal(input logic [1:0] p);
        return p != 2'b10;
    endfunction

    function automatic logic dirty_of(input logic [1:0] fs, input logic [1:0] xs);
        return (fs == 2'b11) || (xs == 2'b11);
    endfunction

endpackage

// File: rtl/csr_status_unit.sv
module csr_status_unit
    import csr_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter bit EXT_PRESENT = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_m,
    input  logic            wr_s,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] mstatus_rd,
    output logic [XLEN-1:0] sstatus_rd
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);
    localparam logic [XLEN-1:0] S_VIEW =
        (ONE << SB_SIE) | (ONE << SB_SPIE) | (ONE << SB_SPP) |
        (XLEN'(3) << SB_FS) | (XLEN'(3) << SB_XS) | (ONE << SB_PUM);

    status_t st_q, st_d;
    logic    sd_q, sd_d;
    logic [XLEN-1:0] word_cur, src;

    function automatic logic [XLEN-1:0] pack(input status_t s, input logic sd);
        logic [XLEN-1:0] w;
        w = '0;
        w[SB_SIE]  = s.sie;
        w[SB_MIE]  = s.mie;
        w[SB_SPIE] = s.spie;
        w[SB_MPIE] = s.mpie;
        w[SB_SPP]  = s.spp;
        w[SB_MPP +: 2] = s.mpp;
        w[SB_FS +: 2]  = s.fs;
        w[SB_XS +: 2]  = s.xs;
        w[SB_MPRV] = s.mprv;
        w[SB_PUM]  = s.pum;
        w[SB_VM +: 5]  = s.vm;
        w[XLEN-1]  = sd;
        return w;
    endfunction

    assign word_cur = pack(st_q, sd_q);
    // supervisor writes merge into the current word first
    assign src = wr_s ? ((word_cur & ~S_VIEW) | (wdata & S_VIEW)) : wdata;

    always_comb begin
        st_d = st_q;
        sd_d = sd_q;
        if (wr_m || wr_s) begin
            st_d.sie  = src[SB_SIE];
            st_d.mie  = src[SB_MIE];
            st_d.spie = src[SB_SPIE];
            st_d.mpie = src[SB_MPIE];
            st_d.spp  = src[SB_SPP];
            st_d.fs   = src[SB_FS +: 2];
            st_d.mprv = src[SB_MPRV];
            st_d.pum  = src[SB_PUM];
            if (EXT_PRESENT)                      st_d.xs  = src[SB_XS +: 2];
            if (priv_legal(src[SB_MPP +: 2]))     st_d.mpp = src[SB_MPP +: 2];
            if (vm_legal(XLEN, src[SB_VM +: 5]))  st_d.vm  = src[SB_VM +: 5];
            sd_d = dirty_of(st_d.fs, st_d.xs);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            sd_q <= 1'b0;
        end else begin
            st_q <= st_d;
            sd_q <= sd_d;
        end
    end

    assign mstatus_rd = word_cur;
    always_comb begin
        sstatus_rd = word_cur & S_VIEW;
        sstatus_rd[XLEN-1] = dirty_of(st_q.fs, st_q.xs);
    end

    p_sd_tracks_r4: assert property (@(posedge clk) disable iff (rst)
        sd_q == ((st_q.fs == 2'b11) || (st_q.xs == 2'b11)));
    p_mpp_legal_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.mpp != 2'b10);
    p_vm_legal_r3: assert property (@(posedge clk) disable iff (rst)
        vm_legal(XLEN, st_q.vm));
    p_xs_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        EXT_PRESENT || st_q.xs == 2'b00);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(wr_m || wr_s) |=> $stable(word_cur));

endmodule

// File: rtl/csr_irq_unit.sv
module csr_irq_unit
    import csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_mip,
    input  logic            wr_sip,
    input  logic            wr_mie,
    input  logic            wr_sie,
    input  logic            wr_deleg,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] mip_rd,
    output logic [XLEN-1:0] mie_rd,
    output logic [XLEN-1:0] deleg_rd,
    output logic [XLEN-1:0] sip_rd,
    output logic [XLEN-1:0] sie_rd
);
    localparam logic [XLEN-1:0] ONE = XLEN'(1);
    localparam logic [XLEN-1:0] PEND_SW = (ONE << IB_SSW) | (ONE << IB_STMR);
    localparam logic [XLEN-1:0] DELEGABLE =
        (ONE << IB_SSW) | (ONE << IB_STMR) | (ONE << IB_SEXT) | (ONE << IB_COP);
    localparam logic [XLEN-1:0] ENABLE_ALL =
        DELEGABLE | (ONE << IB_MSW) | (ONE << IB_MTMR);

    logic [XLEN-1:0] mip_q, mie_q, deleg_q;
    logic [XLEN-1:0] pend_src, en_src;

    // supervisor views merge through the live delegation mask
    assign pend_src = wr_sip ? ((mip_q & ~deleg_q) | (wdata & deleg_q)) : wdata;
    assign en_src   = wr_sie ? ((mie_q & ~deleg_q) | (wdata & deleg_q)) : wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            mip_q   <= '0;
            mie_q   <= '0;
            deleg_q <= '0;
        end else begin
            if (wr_mip || wr_sip)
                mip_q <= (mip_q & ~PEND_SW) | (pend_src & PEND_SW);
            if (wr_mie || wr_sie)
                mie_q <= (mie_q & ~ENABLE_ALL) | (en_src & ENABLE_ALL);
            if (wr_deleg)
                deleg_q <= (deleg_q & ~DELEGABLE) | (wdata & DELEGABLE);
        end
    end

    assign mip_rd   = mip_q;
    assign mie_rd   = mie_q;
    assign deleg_rd = deleg_q;
    assign sip_rd   = mip_q & deleg_q;
    assign sie_rd   = mie_q & deleg_q;

    p_pend_mask_r1: assert property (@(posedge clk) disable iff (rst)
        (mip_q & ~PEND_SW) == '0);
    p_deleg_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (deleg_q & ~DELEGABLE) == '0);
    p_en_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (mie_q & ~ENABLE_ALL) == '0);
    p_sview_undeleg_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_sie && !wr_mie) |=> ((mie_q & ~$past(deleg_q)) == ($past(mie_q) & ~$past(deleg_q))));

endmodule

// File: rtl/csr_misc_unit.sv
module csr_misc_unit
    import csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_mtvec,
    input  logic            wr_stvec,
    input  logic            wr_ucnt,
    input  logic            wr_scnt,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] mtvec_rd,
    output logic [XLEN-1:0] stvec_rd,
    output logic [XLEN-1:0] ucnt_rd,
    output logic [XLEN-1:0] scnt_rd
);
    localparam int NVEC = 2;
    localparam int NCNT = 2;

    logic [NVEC-1:0]         vec_wr;
    logic [XLEN-1:0]         vec_q [NVEC];
    logic [NCNT-1:0]         cnt_wr;
    logic [CNTEN_W-1:0]      cnt_q [NCNT];

    assign vec_wr = {wr_stvec, wr_mtvec};
    assign cnt_wr = {wr_scnt, wr_ucnt};

    for (genvar g = 0; g < NVEC; g++) begin : g_vec
        always_ff @(posedge clk) begin
            if (rst)            vec_q[g] <= '0;
            else if (vec_wr[g]) vec_q[g] <= {wdata[XLEN-1:2], 2'b00};
        end
        p_align_r5: assert property (@(posedge clk) disable iff (rst)
            vec_q[g][1:0] == 2'b00);
        p_vec_hold_r5: assert property (@(posedge clk) disable iff (rst)
            !vec_wr[g] |=> $stable(vec_q[g]));
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)            cnt_q[g] <= '0;
            else if (cnt_wr[g]) cnt_q[g] <= wdata[CNTEN_W-1:0];
        end
    end

    assign mtvec_rd = vec_q[0];
    assign stvec_rd = vec_q[1];
    assign ucnt_rd  = XLEN'(cnt_q[0]);
    assign scnt_rd  = XLEN'(cnt_q[1]);

endmodule

// File: rtl/mcsr_filter.sv
module mcsr_filter
    import csr_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter bit EXT_PRESENT = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [11:0]     csr_addr,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic            rd_en,
    output logic [XLEN-1:0] rd_data,
    output logic            illegal_access
);
    csr_sel_t sel, wsel;
    logic     known;

    logic [XLEN-1:0] mstatus_v, sstatus_v, mip_v, mie_v, deleg_v, sip_v, sie_v;
    logic [XLEN-1:0] mtvec_v, stvec_v, ucnt_v, scnt_v;

    always_comb begin
        sel = '0;
        unique case (csr_addr)
            A_SSTATUS: sel.sstatus = 1'b1;
            A_SIE:     sel.sie     = 1'b1;
            A_STVEC:   sel.stvec   = 1'b1;
            A_SIP:     sel.sip     = 1'b1;
            A_MSTATUS: sel.mstatus = 1'b1;
            A_MDELEG:  sel.mdeleg  = 1'b1;
            A_MIE:     sel.mie     = 1'b1;
            A_MTVEC:   sel.mtvec   = 1'b1;
            A_UCNTEN:  sel.ucnten  = 1'b1;
            A_SCNTEN:  sel.scnten  = 1'b1;
            A_MIP:     sel.mip     = 1'b1;
            default:   sel = '0;
        endcase
    end

    assign known = |sel;
    assign wsel  = wr_en ? sel : '0;

    csr_status_unit #(.XLEN(XLEN), .EXT_PRESENT(EXT_PRESENT)) u_status (
        .clk(clk), .rst(rst),
        .wr_m(wsel.mstatus), .wr_s(wsel.sstatus), .wdata(wr_data),
        .mstatus_rd(mstatus_v), .sstatus_rd(sstatus_v)
    );

    csr_irq_unit #(.XLEN(XLEN)) u_irq (
        .clk(clk), .rst(rst),
        .wr_mip(wsel.mip), .wr_sip(wsel.sip),
        .wr_mie(wsel.mie), .wr_sie(wsel.sie),
        .wr_deleg(wsel.mdeleg), .wdata(wr_data),
        .mip_rd(mip_v), .mie_rd(mie_v), .deleg_rd(deleg_v),
        .sip_rd(sip_v), .sie_rd(sie_v)
    );

    csr_misc_unit #(.XLEN(XLEN)) u_misc (
        .clk(clk), .rst(rst),
        .wr_mtvec(wsel.mtvec), .wr_stvec(wsel.stvec),
        .wr_ucnt(wsel.ucnten), .wr_scnt(wsel.scnten), .wdata(wr_data),
        .mtvec_rd(mtvec_v), .stvec_rd(stvec_v),
        .ucnt_rd(ucnt_v), .scnt_rd(scnt_v)
    );

    always_comb begin
        rd_data = '0;
        if (sel.sstatus) rd_data = sstatus_v;
        if (sel.sie)     rd_data = sie_v;
        if (sel.stvec)   rd_data = stvec_v;
        if (sel.sip)     rd_data = sip_v;
        if (sel.mstatus) rd_data = mstatus_v;
        if (sel.mdeleg)  rd_data = deleg_v;
        if (sel.mie)     rd_data = mie_v;
        if (sel.mtvec)   rd_data = mtvec_v;
        if (sel.ucnten)  rd_data = ucnt_v;
        if (sel.scnten)  rd_data = scnt_v;
        if (sel.mip)     rd_data = mip_v;
    end

    assign illegal_access = rd_en && !known;

    p_illegal_zero_r9: assert property (@(posedge clk) disable iff (rst)
        illegal_access |-> rd_data == '0);
    p_decode_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
    p_sd_view_r8: assert property (@(posedge clk) disable iff (rst)
        sel.sstatus |-> rd_data[XLEN-1] == mstatus_v[XLEN-1]);

endmodule

// File: tb/mcsr_filter_tb.sv
module mcsr_filter_tb_top;
    localparam int  XLEN     = 32;
    localparam time CLK_HALF = 5ns;
    localparam int  NVEC     = 17;

    typedef struct packed {
        logic        we;
        logic [11:0] waddr;
        logic [31:0] wdata;
        logic [11:0] raddr;
        logic [31:0] exp;
    } vec_t;

    // each row: optional write, then a read of raddr one cycle later
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 12'h300, 32'hFFFF_FFFF, 12'h300, 32'h8006_79AA}, // R3 R4 all-ones
        '{1'b1, 12'h300, 32'h0800_1000, 12'h300, 32'h0800_1800}, // R3 mpp refused, vm taken
        '{1'b1, 12'h300, 32'h0000_2122, 12'h100, 32'h0000_2122}, // R8 view
        '{1'b1, 12'h100, 32'hFFFF_FFFF, 12'h100, 32'h8004_6122}, // R8 view write
        '{1'b0, 12'h000, 32'h0000_0000, 12'h300, 32'h8004_6122}, // R8 R4 machine side
        '{1'b1, 12'h344, 32'hFFFF_FFFF, 12'h344, 32'h0000_0022}, // R1
        '{1'b1, 12'h303, 32'hFFFF_FFFF, 12'h303, 32'h0000_1222}, // R2 deleg
        '{1'b1, 12'h304, 32'hFFFF_FFFF, 12'h304, 32'h0000_12AA}, // R2 enable
        '{1'b1, 12'h303, 32'h0000_0020, 12'h144, 32'h0000_0020}, // R7 read view
        '{1'b1, 12'h104, 32'h0000_0000, 12'h304, 32'h0000_128A}, // R7 sie clear
        '{1'b1, 12'h144, 32'h0000_0000, 12'h344, 32'h0000_0002}, // R7 sip clear
        '{1'b0, 12'h000, 32'h0000_0000, 12'h104, 32'h0000_0000}, // R7 sie view
        '{1'b1, 12'h305, 32'hFFFF_FFFF, 12'h305, 32'hFFFF_FFFC}, // R5 mtvec
        '{1'b1, 12'h105, 32'h0000_1237, 12'h105, 32'h0000_1234}, // R5 stvec
        '{1'b1, 12'h320, 32'h0000_00FF, 12'h320, 32'h0000_0007}, // R6 user
        '{1'b1, 12'h321, 32'h0000_000A, 12'h321, 32'h0000_0002}, // R6 super
        '{1'b1, 12'h7FF, 32'h0000_0000, 12'h305, 32'hFFFF_FFFC}  // R9 unmapped write ignored
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [11:0]     csr_addr = '0;
    logic            wr_en = 1'b0;
    logic [XLEN-1:0] wr_data = '0;
    logic            rd_en = 1'b0;
    logic [XLEN-1:0] rd_data;
    logic            illegal_access;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    mcsr_filter #(.XLEN(XLEN), .EXT_PRESENT(1'b0)) dut_i (
        .clk(clk), .rst(rst), .csr_addr(csr_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .illegal_access(illegal_access)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_at(input logic [11:0] a);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; csr_addr = a;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd_at(12'h300); check("R11 mstatus", rd_data, 32'h0);
        rd_at(12'h344); check("R11 mip", rd_data, 32'h0);
        rd_at(12'h305); check("R11 mtvec", rd_data, 32'h0);
        check("R9 no flag on mapped read", {31'b0, illegal_access}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            rd_en = 1'b0;
            wr_en = VECS[i].we; csr_addr = VECS[i].waddr; wr_data = VECS[i].wdata;
            rd_at(VECS[i].raddr);
            check($sformatf("vector %0d", i), rd_data, VECS[i].exp);
        end

        // R9 unmapped read
        rd_at(12'h7C0);
        check("R9 flag", {31'b0, illegal_access}, 32'h1);
        check("R9 data", rd_data, 32'h0);

        // R10 old value during the write cycle, new value after the edge
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; csr_addr = 12'h303; wr_data = 32'h0000_0002;
        #1;
        check("R10 old value", rd_data, 32'h0000_0020);
        rd_at(12'h303);
        check("R10 new value", rd_data, 32'h0000_0002);

        // R4 dirty flag clears once FS leaves all-ones
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b1; csr_addr = 12'h300; wr_data = 32'h0000_4000;
        rd_at(12'h300);
        check("R4 sd clear", rd_data, 32'h0000_4000);

        // R11 reset clears written state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_at(12'h304);
        check("R11 mie after reset", rd_data, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule